// File: doc/BRIEF.md
# Cartridge Bank Controller with Latched Timekeeper

This block sits on the CPU write bus of a cartridge slot. It decodes writes in the lower 32 KiB of the address space into four control functions. It picks the switchable ROM bank. It picks either one of four external RAM banks or one of five timekeeper registers for the external RAM window. It enables or disables that window. It takes a snapshot of the timekeeper on command.

The timekeeper holds seconds, minutes, hours and a 9-bit day count. It advances once for each pulse on a one-cycle tick input. The CPU never reads the running counters directly. Reads of a timekeeper register return a frozen copy. The CPU refreshes that copy with a write of 0 followed by a write of 1 to the latch control. The CPU can also preset the running counters by writing to the selected timekeeper register through the RAM window.

Top module: `cart_bank_rtc`

## Requirements
- R1: A write with address bits [15:13] = 0 and data 0x0A enables the RAM window, and data 0x00 disables it. Any other data leaves the enable unchanged. While the window is disabled, `rd_data` is 0xFF and `ext_ram_sel` is 0.
- R2: A write with address bits [15:13] = 1 loads the ROM bank from data bits [6:0]. A value of zero is stored as one. `rom_bank` is never zero.
- R3: A write with address bits [15:13] = 2 and data 0x00-0x03 sets `ram_bank` to data[1:0] and selects RAM mode. In RAM mode, `ext_ram_sel` is 1 while the window is enabled and `rd_data` is 0xFF. Data 0x08-0x0C selects timekeeper register (data - 8) and clock mode, in which `ext_ram_sel` is 0. Any other data changes nothing.
- R4: A write with address bits [15:13] = 3 works as follows. Data 0x01 while unlatched copies the running counters into the snapshot and sets the latched flag. Data 0x00 while latched clears the flag. Writes of 0x01 while already latched, and all other writes, leave the snapshot unchanged.
- R5: In clock mode with the window enabled, `rd_data` shows the snapshot byte of the selected register. Register 0 is seconds, 1 is minutes, 2 is hours, 3 is day bits [7:0], and 4 is {carry, 6'b0, day[8]}. Unused bits read as 0. The snapshot never changes without a latch write.
- R6: Each `sec_tick` pulse advances the seconds counter. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 into hours. Hours wrap from 23 into days. All of these carries take effect in the same cycle.
- R7: When the day count wraps from 511 to 0, the carry flag is set. It stays set through later ticks.
- R8: A write to address bits [15:13] = 5, with the window enabled and in clock mode, loads the selected running counter from the data byte. For register 4, data[0] loads day[8]. Data[7] = 1 sets the carry flag, and data[7] = 0 leaves it unchanged. If such a write and a tick fall in the same cycle, the write wins and the tick is dropped.
- R9: A write to address bits [15:13] = 5 has no effect on the counters while the window is disabled or in RAM mode.
- R10: After reset, `rom_bank` = 1, `ram_bank` = 0, the window is disabled, RAM mode is selected, the flag is unlatched, and the counters and snapshot are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_hi | input | 3 | CPU address bits [15:13] |
| wr_data | input | 8 | CPU write data |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| rom_bank | output | 7 | Selected switchable ROM bank |
| ram_bank | output | 2 | Selected external RAM bank |
| ext_ram_sel | output | 1 | External RAM owns the RAM window |
| rd_data | output | 8 | Read data for the window when the timekeeper owns it |

## Verification
The hardest state to reach is the day-counter overflow. From reset it would take 512 simulated days of ticks. The bench avoids that by using the preset path. It loads 59 s, 59 min, 23 h and day 511 through the RAM window in clock mode, and a single tick then carries through every field at once. It latches the result and reads all five registers. After that it ticks, rewrites register 4 with bit 7 clear, and latches each time, showing the carry flag survives both. A tick and a preset write placed in the same cycle cover the write-wins rule.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int ROM_W    = 7;
  localparam int RAM_W    = 2;
  localparam int IDX_W    = 3;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HR_W     = 5;
  localparam int DAY_W    = 9;
  localparam int SEC_LAST = 59;
  localparam int MIN_LAST = 59;
  localparam int HR_LAST  = 23;
  localparam logic [7:0] EN_CODE  = 8'h0A;
  localparam logic [7:0] DIS_CODE = 8'h00;
  localparam logic [7:0] IDX_BASE = 8'h08;
  localparam logic [7:0] IDX_TOP  = 8'h0C;

  typedef enum logic [2:0] {
    RGN_ENABLE = 3'd0,
    RGN_ROM    = 3'd1,
    RGN_SEL    = 3'd2,
    RGN_LATCH  = 3'd3,
    RGN_WINDOW = 3'd5
  } region_e;

  typedef struct packed {
    logic             carry;
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } tk_t;
endpackage

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr_hi,
  input  logic [7:0]       wr_data,
  output logic [ROM_W-1:0] rom_bank,
  output logic [RAM_W-1:0] ram_bank,
  output logic             win_en,
  output logic             clk_mode,
  output logic [IDX_W-1:0] reg_idx,
  output logic             latched,
  output logic             capture,
  output logic             tk_load
);
  region_e          rgn;
  logic [ROM_W-1:0] rom_d;
  logic [RAM_W-1:0] ram_d;
  logic             en_d, mode_d, latch_d;
  logic [IDX_W-1:0] idx_d;

  assign rgn = region_e'(wr_addr_hi);

  always_comb begin
    rom_d   = rom_bank;
    ram_d   = ram_bank;
    en_d    = win_en;
    mode_d  = clk_mode;
    idx_d   = reg_idx;
    latch_d = latched;
    capture = 1'b0;
    tk_load = 1'b0;
    if (wr_en) begin
      case (rgn)
        RGN_ENABLE: begin
          if (wr_data == EN_CODE)       en_d = 1'b1;
          else if (wr_data == DIS_CODE) en_d = 1'b0;
        end
        RGN_ROM: begin
          rom_d = (wr_data[ROM_W-1:0] == '0) ? ROM_W'(1) : wr_data[ROM_W-1:0];
        end
        RGN_SEL: begin
          if (wr_data < 8'h04) begin
            ram_d  = wr_data[RAM_W-1:0];
            mode_d = 1'b0;
          end else if (wr_data >= IDX_BASE && wr_data <= IDX_TOP) begin
            idx_d  = IDX_W'(wr_data - IDX_BASE);
            mode_d = 1'b1;
          end
        end
        RGN_LATCH: begin
          if (wr_data == 8'h01 && !latched) begin
            capture = 1'b1;
            latch_d = 1'b1;
          end else if (wr_data == 8'h00 && latched) begin
            latch_d = 1'b0;
          end
        end
        RGN_WINDOW: tk_load = win_en && clk_mode;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= ROM_W'(1);
      ram_bank <= '0;
      win_en   <= 1'b0;
      clk_mode <= 1'b0;
      reg_idx  <= '0;
      latched  <= 1'b0;
    end else begin
      rom_bank <= rom_d;
      ram_bank <= ram_d;
      win_en   <= en_d;
      clk_mode <= mode_d;
      reg_idx  <= idx_d;
      latched  <= latch_d;
    end
  end
endmodule

// File: rtl/cbr_timekeeper.sv
module cbr_timekeeper
  import cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [7:0]       load_data,
  output tk_t              live
);
  tk_t          nxt;
  logic         sec_wrap, min_wrap, hr_wrap;
  logic [DAY_W:0] day_inc;

  assign sec_wrap = live.sec >= SEC_W'(SEC_LAST);
  assign min_wrap = sec_wrap && (live.min >= MIN_W'(MIN_LAST));
  assign hr_wrap  = min_wrap && (live.hr >= HR_W'(HR_LAST));
  assign day_inc  = {1'b0, live.day} + (DAY_W+1)'(1);

  always_comb begin
    nxt = live;
    if (load) begin
      case (load_idx)
        3'd0: nxt.sec = load_data[SEC_W-1:0];
        3'd1: nxt.min = load_data[MIN_W-1:0];
        3'd2: nxt.hr  = load_data[HR_W-1:0];
        3'd3: nxt.day[7:0] = load_data;
        3'd4: begin
          nxt.day[DAY_W-1] = load_data[0];
          nxt.carry        = live.carry | load_data[7];
        end
        default: ;
      endcase
    end else if (tick) begin
      nxt.sec = sec_wrap ? '0 : live.sec + SEC_W'(1);
      if (sec_wrap) nxt.min = min_wrap ? '0 : live.min + MIN_W'(1);
      if (min_wrap) nxt.hr  = hr_wrap ? '0 : live.hr + HR_W'(1);
      if (hr_wrap) begin
        nxt.day = day_inc[DAY_W-1:0];
        if (day_inc[DAY_W]) nxt.carry = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= '0;
    else        live <= nxt;
  end
endmodule

// File: rtl/cbr_snapshot.sv
module cbr_snapshot
  import cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  tk_t              live,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_out
);
  tk_t snap;
  tk_t snap_d;

  assign snap_d = capture ? live : snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else        snap <= snap_d;
  end

  always_comb begin
    case (idx)
      3'd0:    byte_out = 8'(snap.sec);
      3'd1:    byte_out = 8'(snap.min);
      3'd2:    byte_out = 8'(snap.hr);
      3'd3:    byte_out = snap.day[7:0];
      3'd4:    byte_out = {snap.carry, 6'b0, snap.day[DAY_W-1]};
      default: byte_out = 8'hFF;
    endcase
  end
endmodule

// File: rtl/cart_bank_rtc.sv
module cart_bank_rtc
  import cbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr_hi,
  input  logic [7:0]       wr_data,
  input  logic             sec_tick,
  output logic [ROM_W-1:0] rom_bank,
  output logic [RAM_W-1:0] ram_bank,
  output logic             ext_ram_sel,
  output logic [7:0]       rd_data
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic             win_en, clk_mode, latched, capture, tk_load;
  logic [IDX_W-1:0] reg_idx;
  logic [7:0]       snap_byte;
  tk_t              live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  cbr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr_hi(wr_addr_hi),
    .wr_data(wr_data), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .win_en(win_en), .clk_mode(clk_mode), .reg_idx(reg_idx),
    .latched(latched), .capture(capture), .tk_load(tk_load)
  );

  cbr_timekeeper u_tk (
    .clk(clk), .rst_n(rst_core_n), .tick(sec_tick), .load(tk_load),
    .load_idx(reg_idx), .load_data(wr_data), .live(live_q)
  );

  cbr_snapshot u_snap (
    .clk(clk), .rst_n(rst_core_n), .capture(capture), .live(live_q),
    .idx(reg_idx), .byte_out(snap_byte)
  );

  assign ext_ram_sel = win_en && !clk_mode;
  assign rd_data     = (win_en && clk_mode) ? snap_byte : 8'hFF;
endmodule

// File: rtl/cart_bank_rtc_chk.sv
module cart_bank_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr_hi,
  input logic [7:0] wr_data,
  input logic       sec_tick,
  input logic [6:0] rom_bank,
  input logic [7:0] rd_data,
  input logic       latched,
  input logic [5:0] live_sec,
  input logic       live_carry
);
  // R2: bank zero is never presented
  p_rom_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank != 7'd0);

  // R2: bank only moves after a write
  p_rom_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(rom_bank));

  // R5: ticks alone never disturb what the CPU reads
  p_read_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(rd_data));

  // R4: latch-one while unlatched sets the flag
  p_latch_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr_hi == 3'd3 && wr_data == 8'h01 && !latched) |=> latched);

  // R6: a tick below the wrap point steps seconds by one
  p_sec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && live_sec < 6'd59) |=> live_sec == $past(live_sec) + 6'd1);

  // R7: the overflow flag is sticky apart from CPU writes
  p_carry_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_carry && !wr_en) |=> live_carry);
endmodule

bind cart_bank_rtc cart_bank_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr_hi(wr_addr_hi),
  .wr_data(wr_data), .sec_tick(sec_tick), .rom_bank(rom_bank),
  .rd_data(rd_data), .latched(latched), .live_sec(live_q.sec),
  .live_carry(live_q.carry)
);

// File: tb/sim_cart_bank_rtc.sv
module sim_cart_bank_rtc;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, sec_tick;
  logic [2:0] wr_addr_hi;
  logic [7:0] wr_data;
  logic [6:0] rom_bank;
  logic [1:0] ram_bank;
  logic       ext_ram_sel;
  logic [7:0] rd_data;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_rtc u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr_hi(wr_addr_hi),
    .wr_data(wr_data), .sec_tick(sec_tick), .rom_bank(rom_bank),
    .ram_bank(ram_bank), .ext_ram_sel(ext_ram_sel), .rd_data(rd_data)
  );

  // {addr[15:0], data, rom_bank, {5'b0, ext_ram_sel, ram_bank}, rd_data}
  localparam int NV = 13;
  localparam logic [47:0] VEC [NV] = '{
    48'h2000_00_01_00_FF, 48'h2000_85_05_00_FF, 48'h3FFF_7F_7F_00_FF,
    48'h0000_0A_7F_04_FF, 48'h4000_02_7F_06_FF, 48'h4000_05_7F_06_FF,
    48'h4000_08_7F_02_00, 48'h4000_0D_7F_02_00, 48'h0000_33_7F_02_00,
    48'h1FFF_00_7F_02_FF, 48'h0000_0A_7F_02_00, 48'h4000_03_7F_07_FF,
    48'h6000_01_7F_07_FF
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr_hi = addr[15:13]; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic latch();
    do_write(16'h6000, 8'h00);
    do_write(16'h6000, 8'h01);
  endtask

  task automatic sel_reg(input int idx);
    do_write(16'h4000, 8'h08 + 8'(idx));
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] val);
    sel_reg(idx);
    do_write(16'hA000, val);
  endtask

  task automatic rd_reg(input int idx, input logic [7:0] exp, input string req);
    sel_reg(idx);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; sec_tick = 1'b0; wr_addr_hi = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 rom_bank", {1'b0, rom_bank}, 8'h01);
    chk("R10 ram/sel", {5'b0, ext_ram_sel, ram_bank}, 8'h00);
    chk("R10 rd_data", rd_data, 8'hFF);

    // R1 R2 R3: vector table
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][47:32], VEC[i][31:24]);
      chk($sformatf("R1/R2/R3 vec%0d rom", i), {1'b0, rom_bank}, VEC[i][23:16]);
      chk($sformatf("R1/R2/R3 vec%0d sel", i), {5'b0, ext_ram_sel, ram_bank}, VEC[i][15:8]);
      chk($sformatf("R1/R2/R3 vec%0d rd", i), rd_data, VEC[i][7:0]);
    end

    // R4: snapshot frozen while latched; re-latch needs 0 then 1
    repeat (3) tick();
    rd_reg(0, 8'h00, "R4 frozen after ticks");
    do_write(16'h6000, 8'h01);
    chk("R4 second one ignored", rd_data, 8'h00);
    latch();
    chk("R4 relatch sees 3s", rd_data, 8'h03);

    // R6: seconds wrap into minutes after preset 58
    wr_reg(0, 8'd58);
    tick(); tick();
    latch();
    rd_reg(0, 8'h00, "R6 sec wrap");
    rd_reg(1, 8'h01, "R6 min carry");

    // R9: preset ignored in RAM mode and when disabled
    do_write(16'h4000, 8'h00);
    do_write(16'hA000, 8'h20);
    sel_reg(0);
    do_write(16'h0000, 8'h00);
    do_write(16'hA000, 8'h11);
    do_write(16'h0000, 8'h0A);
    latch();
    rd_reg(0, 8'h00, "R9 seconds untouched");

    // R6: minutes into hours
    wr_reg(2, 8'd3); wr_reg(1, 8'd59); wr_reg(0, 8'd59);
    tick(); latch();
    rd_reg(2, 8'h04, "R6 hour carry");
    rd_reg(1, 8'h00, "R6 min wrap");

    // R7: full overflow
    wr_reg(0, 8'd59); wr_reg(1, 8'd59); wr_reg(2, 8'd23);
    wr_reg(3, 8'hFF); wr_reg(4, 8'h01);
    tick(); latch();
    rd_reg(0, 8'h00, "R7 sec");
    rd_reg(1, 8'h00, "R7 min");
    rd_reg(2, 8'h00, "R7 hour");
    rd_reg(3, 8'h00, "R7 day low");
    rd_reg(4, 8'h80, "R7 carry set day8 clear");
    tick(); latch();
    rd_reg(4, 8'h80, "R7 carry sticky");
    rd_reg(0, 8'h01, "R7 counting resumes");

    // R8: bit7 zero preserves carry, bit7/bit0 load
    wr_reg(4, 8'h00); latch();
    rd_reg(4, 8'h80, "R8 carry preserved");
    wr_reg(4, 8'h81); latch();
    rd_reg(4, 8'h81, "R8 day8 loaded");

    // R6: hours into days
    wr_reg(4, 8'h00); wr_reg(3, 8'h05); wr_reg(2, 8'd23);
    wr_reg(1, 8'd59); wr_reg(0, 8'd59);
    tick(); latch();
    rd_reg(3, 8'h06, "R6 day carry");
    rd_reg(2, 8'h00, "R6 hour wrap");

    // R8: write beats a same-cycle tick
    sel_reg(0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr_hi = 3'd5; wr_data = 8'h0A; sec_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0;
    latch();
    rd_reg(0, 8'h0A, "R8 write wins over tick");

    // R1: disable forces 0xFF even in clock mode
    do_write(16'h0000, 8'h00);
    chk("R1 disabled read", rd_data, 8'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule